// File: doc/BRIEF.md
# Sequential-Write Two-Wire Control Slave

This block is a two-wire serial slave that owns a small bank of byte-wide control registers, each bit of which enables one clock output. Both bus lines are oversampled by a fast system clock, passed through synchronizers, and turned into SCL edge strobes plus START and STOP events. The slave answers one 7-bit device address, chosen from a fixed table by three strap inputs, and acknowledges by asserting an open-drain pull-down request on SDATA.

There is no command or offset byte. After a matching write address, data bytes fill register 0, then 1, and onward up to the size of the bank. A read address returns the bank in the same order. Changing a late register therefore means resending every earlier one.

The controller is a single enumerated state machine. Its states are `S_IDLE` (bus free), `S_ADDR` (shifting in the address byte), `S_ADDR_ACK` (driving the address acknowledge), `S_WR_DATA` (shifting in a data byte), `S_WR_ACK` (driving a data acknowledge), `S_RD_DATA` (shifting a register byte out), `S_RD_ACK` (sampling the master's acknowledge) and `S_IGNORE` (silent until the next START). Its transitions are: START, from any state, to `S_ADDR`. STOP, from any state, to `S_IDLE`. `S_ADDR` goes to `S_ADDR_ACK` on a match or to `S_IGNORE` on a miss, at the SCL fall that ends bit 8. `S_ADDR_ACK` goes to `S_RD_DATA` or `S_WR_DATA` at the next fall, following R/W#. `S_WR_DATA` goes to `S_WR_ACK` while room remains and to `S_IGNORE` when the bank is full. `S_WR_ACK` returns to `S_WR_DATA` at the next fall. `S_RD_DATA` goes to `S_RD_ACK` after eight bits. `S_RD_ACK` goes back to `S_RD_DATA` on a master ACK and to `S_IGNORE` on a NACK.

Top module: `smb_ctrl_slave`

## Requirements
- R1: A falling SDATA while SCL is high is a START and sends the slave to address reception from any state. A rising SDATA while SCL is high is a STOP, which returns it to idle with SDATA released.
- R2: Received bits are sampled on the rising edge of SCL, MSB first. The slave starts pulling SDATA low only while SCL is low, and read data bits stay stable for the whole SCL high phase.
- R3: The address byte is 7 address bits followed by R/W# in bit 0, where 1 means read. The slave acknowledges a byte whose upper 7 bits equal the strap-selected address. For strap values {strap[2],strap[1],strap[0]} 0 through 7, the address bytes with R/W# = 0 are D0+0E, DC, DA, D8, D6, D4, D0 and D2 hex, that is DE, DC, DA, D8, D6, D4, D0, D2.
- R4: A non-matching address gets no acknowledge. The slave then leaves SDATA released and every register unchanged until the next START.
- R5: After a write address, data bytes go into register 0, 1, 2 and so on, in order, and each one is acknowledged. Register i appears on ctrl_regs[8i+7:8i].
- R6: Data bytes past the last register (the 11th and later with NUM_BYTES = 10) are not acknowledged and change no register.
- R7: After a read address, the slave sends register 0 onward, MSB first, for as long as the master acknowledges. Bytes past the last register read as FF hex. A master NACK makes the slave release SDATA and ignore the bus until the next START.
- R8: A repeated START resets the byte pointer, so the next write data byte lands in register 0 again.
- R9: An asynchronous reset sets every register bit to 1 (all outputs enabled) and releases SDATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| strap | input | 3 | Address-select straps |
| sda_drive_low | output | 1 | Open-drain request: 1 pulls SDATA low |
| ctrl_regs | output | 8*NUM_BYTES | Register bank, register i in bits 8i+7:8i |

## Verification
The bench uses the defaults: NUM_BYTES = 10 and two synchronizer stages, with a bit period of 32 system clocks. With a ten-byte bank, an 11-byte write and an 11-byte read finish quickly, so the overflow NACK and the FF fill past the last register are both covered. The three-bit strap keeps the full sweep small: every strap value is tried against all eight table addresses, and each pairing is followed by a data byte that must land in register 0 only on a match.

// File: rtl/smb_ctrl_pkg.sv
package smb_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_DATA,
        S_WR_ACK,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } smb_state_e;

    // Strap value to 7-bit device address (address byte shifted right by one).
    function automatic logic [6:0] strap_to_addr(input logic [2:0] s);
        logic [6:0] a;
        unique case (s)
            3'd0: a = 7'h6F;
            3'd1: a = 7'h6E;
            3'd2: a = 7'h6D;
            3'd3: a = 7'h6C;
            3'd4: a = 7'h6B;
            3'd5: a = 7'h6A;
            3'd6: a = 7'h68;
            3'd7: a = 7'h69;
            default: a = 7'h6F;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/smb_line_cond.sv
// Synchronizes both bus lines and derives SCL edges and START/STOP events.
module smb_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] pins;
    logic [1:0] lvl;
    logic [1:0] lvl_q;

    assign pins = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : gen_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pins[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 2'b11;
        else        lvl_q <= lvl;
    end

    assign scl_lvl   = lvl[1];
    assign sda_lvl   = lvl[0];
    assign scl_rise  = lvl[1] & ~lvl_q[1];
    assign scl_fall  = ~lvl[1] & lvl_q[1];
    assign start_det = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
    assign stop_det  = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];

endmodule

// File: rtl/smb_reg_bank.sv
// Byte-wide control registers with one write port and one read mux.
module smb_reg_bank #(
    parameter int NUM_BYTES = 10,
    parameter int PTR_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [PTR_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [8*NUM_BYTES-1:0] regs_flat
);

    logic [7:0] mem [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : gen_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= 8'hFF;
            else if (wr_en && (wr_idx == PTR_W'(g)))
                mem[g] <= wr_data;
        end
        assign regs_flat[8*g +: 8] = mem[g];
    end

    // Past the end of the bank the read value is all ones (line released).
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_idx == PTR_W'(i)) rd_data = mem[i];
        end
    end

endmodule

// File: rtl/smb_ctrl_slave.sv
module smb_ctrl_slave
    import smb_ctrl_pkg::*;
#(
    parameter int NUM_BYTES   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [2:0]             strap,
    output logic                   sda_drive_low,
    output logic [8*NUM_BYTES-1:0] ctrl_regs
);

    localparam int PTR_W = $clog2(NUM_BYTES + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_BYTES);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    smb_state_e       state_q, state_d;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [PTR_W-1:0] ptr_q;
    logic             rw_q;
    logic             m_nack;
    logic             byte_end;
    logic             addr_hit;
    logic             room;
    logic             wr_en;
    logic [7:0]       rd_data;

    smb_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_end = scl_fall && (bit_cnt == 4'd8);
    assign addr_hit = (rx_sh[7:1] == strap_to_addr(strap));
    assign room     = (ptr_q < PTR_END);
    assign wr_en    = (state_q == S_WR_DATA) && byte_end && room
                      && !start_det && !stop_det;

    smb_reg_bank #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr_q),
        .wr_data   (rx_sh),
        .rd_idx    (ptr_q),
        .rd_data   (rd_data),
        .regs_flat (ctrl_regs)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_ADDR;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (byte_end) state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall) state_d = rw_q ? S_RD_DATA : S_WR_DATA;
                S_WR_DATA:  if (byte_end) state_d = room ? S_WR_ACK : S_IGNORE;
                S_WR_ACK:   if (scl_fall) state_d = S_WR_DATA;
                S_RD_DATA:  if (byte_end) state_d = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) state_d = m_nack ? S_IGNORE : S_RD_DATA;
                S_IGNORE:   state_d = S_IGNORE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: bit counter, shifters, byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= 8'hFF;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            m_nack  <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
            ptr_q   <= '0;
            tx_sh   <= 8'hFF;
        end else if (stop_det) begin
            bit_cnt <= '0;
            tx_sh   <= 8'hFF;
        end else begin
            unique case (state_q)
                S_ADDR, S_WR_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state_q == S_ADDR) rw_q <= rx_sh[0];
                        else if (room)         ptr_q <= ptr_q + 1'b1;
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        tx_sh <= rd_data;
                        if (room) ptr_q <= ptr_q + 1'b1;
                    end
                end
                S_RD_DATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        tx_sh   <= 8'hFF;
                    end else if (scl_fall) begin
                        tx_sh <= {tx_sh[6:0], 1'b1};
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        m_nack <= sda_lvl;
                    end else if (scl_fall && !m_nack) begin
                        tx_sh <= rd_data;
                        if (room) ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            S_ADDR_ACK, S_WR_ACK: sda_drive_low = 1'b1;
            S_RD_DATA:            sda_drive_low = ~tx_sh[7];
            default:              sda_drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/smb_ctrl_slave_chk.sv
module smb_ctrl_slave_chk #(
    parameter int NUM_BYTES = 10,
    parameter int PTR_W     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   scl_lvl,
    input logic                   sda_drive_low,
    input logic [PTR_W-1:0]       ptr,
    input logic                   wr_en,
    input logic [8*NUM_BYTES-1:0] ctrl_regs
);

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low); // R1

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_lvl); // R2

    AST_START_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ptr == '0)); // R8

    AST_PTR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(NUM_BYTES)); // R6

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr < PTR_W'(NUM_BYTES))); // R6

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_regs)); // R4

endmodule

bind smb_ctrl_slave smb_ctrl_slave_chk #(
    .NUM_BYTES (NUM_BYTES),
    .PTR_W     (PTR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .scl_lvl       (scl_lvl),
    .sda_drive_low (sda_drive_low),
    .ptr           (ptr_q),
    .wr_en         (wr_en),
    .ctrl_regs     (ctrl_regs)
);

// File: tb/smb_ctrl_slave_test.sv
module smb_ctrl_slave_test;

    localparam int NB = 10;
    localparam int Q  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl = 1'b1;
    logic            m_sda = 1'b1;
    logic [2:0]      strap = 3'd0;
    logic            drv;
    logic [NB*8-1:0] regs;
    logic            sda_line;

    logic [7:0] model [NB];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign sda_line = m_sda & ~drv;

    always #5 clk = ~clk;

    smb_ctrl_slave #(.NUM_BYTES(NB), .SYNC_STAGES(2)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .strap         (strap),
        .sda_drive_low (drv),
        .ctrl_regs     (regs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] addr_of(input int s);
        if (s < 6) return 8'(8'hDE - 2 * s);
        return (s == 6) ? 8'hD0 : 8'hD2;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b, output logic stable);
        logic s2;
        stable = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            s2 = sda_line;
            if (s2 !== b[i]) stable = 1'b0;
            scl = 1'b0;
            tick(Q);
        end
        m_sda = mack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NB; i++) chk(tag, 32'(regs[8*i +: 8]), 32'(model[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic       stb;

        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        tick(4);
        // R9: reset state
        check_bank("R9 reset value");
        chk("R9 sda released in reset", 32'(drv), 0);
        rst_n = 1'b1;
        tick(4);

        // R3/R4: every strap against every table address
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            tick(Q);
            for (int a = 0; a < 8; a++) begin
                logic [7:0] d;
                d = 8'(8'h40 | (s << 3) | a);
                bus_start();
                send_byte(addr_of(a), ack);
                chk((a == s) ? "R3 address ack" : "R4 no ack on miss", 32'(ack), (a == s) ? 1 : 0);
                send_byte(d, ack);
                chk("R4 data ack only after match", 32'(ack), (a == s) ? 1 : 0);
                if (a == s) model[0] = d;
                bus_stop();
                chk("R4 reg0 after strap sweep", 32'(regs[7:0]), 32'(model[0]));
                chk("R1 released after stop", 32'(drv), 0);
            end
        end

        strap = 3'd3;
        tick(Q);

        // R5/R6: full bank plus one extra byte
        bus_start();
        send_byte(addr_of(3), ack);
        chk("R3 write address ack", 32'(ack), 1);
        for (int i = 0; i < NB; i++) begin
            model[i] = 8'(i * 8'h11 + 8'h03);
            send_byte(model[i], ack);
            chk("R5 data byte ack", 32'(ack), 1);
        end
        send_byte(8'h5A, ack);
        chk("R6 overflow byte nack", 32'(ack), 0);
        bus_stop();
        check_bank("R6 bank after overflow");

        // R5: short write touches only the first registers
        bus_start();
        send_byte(addr_of(3), ack);
        for (int i = 0; i < 3; i++) begin
            model[i] = 8'(8'hA0 + i);
            send_byte(model[i], ack);
            chk("R5 short write ack", 32'(ack), 1);
        end
        bus_stop();
        check_bank("R5 short write order");

        // R8: repeated start resets pointer
        bus_start();
        send_byte(addr_of(3), ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        model[0] = 8'h11;
        model[1] = 8'h22;
        bus_start();
        send_byte(addr_of(3), ack);
        chk("R8 address ack after repeated start", 32'(ack), 1);
        send_byte(8'h77, ack);
        model[0] = 8'h77;
        bus_stop();
        check_bank("R8 repeated start lands in reg0");

        // R7/R2: read whole bank and one beyond, NACK on last
        bus_start();
        send_byte(addr_of(3) | 8'h01, ack);
        chk("R7 read address ack", 32'(ack), 1);
        for (int i = 0; i <= NB; i++) begin
            recv_byte(i != NB, rb, stb);
            chk("R7 read data", 32'(rb), (i < NB) ? 32'(model[i]) : 32'hFF);
            chk("R2 data stable while SCL high", 32'(stb), 1);
        end
        tick(Q);
        chk("R7 released after master nack", 32'(drv), 0);
        bus_stop();

        // R7: after a NACK the slave stays silent until START
        bus_start();
        send_byte(addr_of(3) | 8'h01, ack);
        recv_byte(1'b0, rb, stb);
        chk("R7 first byte of short read", 32'(rb), 32'(model[0]));
        send_byte(8'h00, ack);
        chk("R7 silent after nack", 32'(ack), 0);
        check_bank("R7 bank untouched after nack");
        bus_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule